// File: doc/BRIEF.md
# Lockable Configuration and Monitor-Status Register

This block holds one small control/status register for a mixed-signal support chip. The register has a two-bit lock code that decides whether potentiometer wiper writes may proceed, and a two-bit field that selects the power-on reset delay. It also holds one latched status flag per supply monitor. The lock code and the delay field behave as nonvolatile storage. They are plain flops that take their defaults only when a one-time initial-load input is pulsed, and they keep their contents across the ordinary power-up reset. The status flags are volatile and that reset clears them.

A write strobe carries a data byte into the register. While the hardware write-protect pin is high, the nonvolatile fields refuse every write, and wiper writes are refused whatever the lock code holds. A status flag can be written to 1 only while its monitor's reset output is high. Once that output drops, the flag falls back to 0 by itself. The register contents and the registered "wiper write permitted" signal come straight from flops.

Register layout used throughout: bits [1:0] lock code, bits [3:2] delay select, bit 4 flag for monitor 0, bit 5 flag for monitor 1, bits [7:6] unused.

Top module: `cfg_lock_reg`

## Requirements
- R1: One cycle after `init_load` is high, bits [1:0] read 00 and bits [3:2] read 01.
- R2: A write with `wp_pin` low and `init_load` low loads `wr_data[1:0]` into the lock code and `wr_data[3:2]` into the delay select. Both are visible on `reg_out` one cycle later.
- R3: While `wp_pin` is high, a write leaves `reg_out[3:0]` unchanged.
- R4: `wiper_wr_ok` is 1 exactly when the lock code registered at the same edge is 00 and `wp_pin` was low at that edge. Lock codes 01, 10 and 11 all give 0.
- R5: A cycle with `pwr_rst` high clears both flags (`reg_out[5:4]` = 00), even if a write is present in that cycle. It leaves `reg_out[3:0]` as it was.
- R6: A write with a 1 in bit 4+i sets flag i only if `mon_rst_hi[i]` is high in that cycle. Otherwise the flag stays 0.
- R7: A flag reads 0 from the cycle after its `mon_rst_hi` input is sampled low. If a set and a low monitor fall in the same cycle, the clear wins.
- R8: A write with a 0 in bit 4+i clears flag i.
- R9: `wp_pin` has no effect on writes to the status flags.
- R10: `reg_out[7:6]` always read 0, whatever data is written.
- R11: When `init_load` and a write fall in the same cycle, the defaults of R1 win for the nonvolatile fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_rst | input | 1 | Synchronous active-high power-up reset; clears the volatile flags only |
| init_load | input | 1 | One-time load of defaults into the nonvolatile fields |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data byte |
| wp_pin | input | 1 | Hardware write protect, active high |
| mon_rst_hi | input | 2 | Reset outputs of the supply monitors, bit i for monitor i |
| reg_out | output | 8 | Register contents |
| wiper_wr_ok | output | 1 | Wiper write permitted |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both. A flag write of 1 can arrive together with its monitor output being low, or just after that output has fallen. A flag write can also coincide with `pwr_rst`. The bench drives each pair on one edge and, on the next edge, expects the flag to read 0, because the clear wins in both cases. It also lines up `init_load` with a write and `wp_pin` with a write, and requires the defaults, or the unchanged nonvolatile bits, on the following cycle.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int unsigned CFG_REG_W       = 8;
  localparam int unsigned CFG_LOCK_W      = 2;
  localparam int unsigned CFG_DLY_W       = 2;
  localparam int unsigned CFG_NUM_MON     = 2;
  localparam int unsigned CFG_DLY_DEFAULT = 1;
endpackage

// File: rtl/cfg_nv_field.sv
module cfg_nv_field #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] DEFAULT = '0
) (
  input  logic         clk,
  input  logic         init_load,
  input  logic         nv_wr,
  input  logic         wp_pin,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (init_load)  q <= DEFAULT;
    else if (nv_wr) q <= wr_val;
  end

  // R1
  nv_default_chk: assert property (@(posedge clk) init_load |=> (q == DEFAULT));
  // R3
  nv_wp_hold_chk: assert property (@(posedge clk) disable iff (init_load)
    (wp_pin && !init_load) |=> $stable(q));
endmodule

// File: rtl/cfg_mon_flag.sv
module cfg_mon_flag (
  input  logic clk,
  input  logic pwr_rst,
  input  logic mon_hi,
  input  logic wr_en,
  input  logic wr_bit,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (pwr_rst)     flag <= 1'b0;
    else if (!mon_hi) flag <= 1'b0;
    else if (wr_en)   flag <= wr_bit;
  end

  // R7
  flag_drop_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    !mon_hi |=> !flag);
  // R6
  flag_set_gate_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    $rose(flag) |-> ($past(mon_hi) && $past(wr_en) && $past(wr_bit)));
  // R8
  flag_wr0_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (wr_en && !wr_bit) |=> !flag);
endmodule

// File: rtl/cfg_wiper_gate.sv
module cfg_wiper_gate #(
  parameter int unsigned LOCK_W = 2,
  parameter logic [LOCK_W-1:0] LOCK_DEFAULT = '0
) (
  input  logic              clk,
  input  logic              init_load,
  input  logic              nv_wr,
  input  logic              wp_pin,
  input  logic [LOCK_W-1:0] wr_lock,
  input  logic [LOCK_W-1:0] lock_q,
  output logic              wiper_wr_ok
);
  logic open_next;

  always_comb begin
    if (init_load)  open_next = (LOCK_DEFAULT == '0);
    else if (nv_wr) open_next = (wr_lock == '0);
    else            open_next = (lock_q == '0);
  end

  always_ff @(posedge clk) wiper_wr_ok <= open_next && !wp_pin;
endmodule

// File: rtl/cfg_lock_reg.sv
module cfg_lock_reg
  import cfg_lock_pkg::*;
#(
  parameter int unsigned REG_W       = CFG_REG_W,
  parameter int unsigned LOCK_W      = CFG_LOCK_W,
  parameter int unsigned DLY_W       = CFG_DLY_W,
  parameter int unsigned NUM_MON     = CFG_NUM_MON,
  parameter int unsigned DLY_DEFAULT = CFG_DLY_DEFAULT
) (
  input  logic               clk,
  input  logic               pwr_rst,
  input  logic               init_load,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               wp_pin,
  input  logic [NUM_MON-1:0] mon_rst_hi,
  output logic [REG_W-1:0]   reg_out,
  output logic               wiper_wr_ok
);
  localparam int unsigned LOCK_LSB = 0;
  localparam int unsigned DLY_LSB  = LOCK_LSB + LOCK_W;
  localparam int unsigned FLAG_LSB = DLY_LSB + DLY_W;
  localparam int unsigned USED_W   = FLAG_LSB + NUM_MON;
  localparam logic [LOCK_W-1:0] LOCK_DEF = '0;
  localparam logic [DLY_W-1:0]  DLY_DEF  = DLY_W'(DLY_DEFAULT);

  logic               nv_wr;
  logic [LOCK_W-1:0]  lock_q;
  logic [DLY_W-1:0]   dly_q;
  logic [NUM_MON-1:0] flags_q;

  assign nv_wr = wr_en && !wp_pin;

  cfg_nv_field #(.W(LOCK_W), .DEFAULT(LOCK_DEF)) u_lock (
    .clk(clk), .init_load(init_load), .nv_wr(nv_wr), .wp_pin(wp_pin),
    .wr_val(wr_data[LOCK_LSB +: LOCK_W]), .q(lock_q));

  cfg_nv_field #(.W(DLY_W), .DEFAULT(DLY_DEF)) u_dly (
    .clk(clk), .init_load(init_load), .nv_wr(nv_wr), .wp_pin(wp_pin),
    .wr_val(wr_data[DLY_LSB +: DLY_W]), .q(dly_q));

  cfg_wiper_gate #(.LOCK_W(LOCK_W), .LOCK_DEFAULT(LOCK_DEF)) u_gate (
    .clk(clk), .init_load(init_load), .nv_wr(nv_wr), .wp_pin(wp_pin),
    .wr_lock(wr_data[LOCK_LSB +: LOCK_W]), .lock_q(lock_q),
    .wiper_wr_ok(wiper_wr_ok));

  for (genvar i = 0; i < NUM_MON; i++) begin : g_flag
    cfg_mon_flag u_flag (
      .clk(clk), .pwr_rst(pwr_rst), .mon_hi(mon_rst_hi[i]), .wr_en(wr_en),
      .wr_bit(wr_data[FLAG_LSB + i]), .flag(flags_q[i]));
  end

  assign reg_out[LOCK_LSB +: LOCK_W]  = lock_q;
  assign reg_out[DLY_LSB +: DLY_W]    = dly_q;
  assign reg_out[FLAG_LSB +: NUM_MON] = flags_q;

  if (REG_W > USED_W) begin : g_pad
    logic unused_wr_pad;
    assign reg_out[REG_W-1:USED_W] = '0;
    assign unused_wr_pad = ^wr_data[REG_W-1:USED_W];
  end

  // R4
  wiper_open_chk: assert property (@(posedge clk) disable iff (init_load)
    wiper_wr_ok |-> (lock_q == '0));
  // R4
  wp_blocks_wiper_chk: assert property (@(posedge clk) disable iff (init_load)
    wp_pin |=> !wiper_wr_ok);
  // R5
  rst_clears_flags_chk: assert property (@(posedge clk) disable iff (init_load)
    pwr_rst |=> (flags_q == '0));
  // R9
  flag_wp_free_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    (wr_en && wp_pin && (mon_rst_hi == '1)) |=>
      (flags_q == $past(wr_data[FLAG_LSB +: NUM_MON])));
endmodule

// File: tb/cfg_lock_reg_tb.sv
module cfg_lock_reg_tb;
  logic       clk = 1'b0;
  logic       pwr_rst = 1'b0, init_load = 1'b0, wr_en = 1'b0, wp_pin = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] mon_rst_hi = '0;
  logic [7:0] reg_out;
  logic       wiper_wr_ok;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct { logic [7:0] r; logic ok; string tag; } exp_t;
  exp_t sb[$];

  logic [1:0] m_lock, m_dly;
  logic [1:0] m_flag;

  always #10 clk = ~clk;

  cfg_lock_reg u_dut (
    .clk(clk), .pwr_rst(pwr_rst), .init_load(init_load), .wr_en(wr_en),
    .wr_data(wr_data), .wp_pin(wp_pin), .mon_rst_hi(mon_rst_hi),
    .reg_out(reg_out), .wiper_wr_ok(wiper_wr_ok));

  task automatic step(input bit init, input bit prst, input bit we,
                      input logic [7:0] d, input bit wp, input logic [1:0] mon,
                      input string tag);
    exp_t e;
    @(negedge clk);
    init_load = init; pwr_rst = prst; wr_en = we; wr_data = d;
    wp_pin = wp; mon_rst_hi = mon;
    if (init) begin m_lock = 2'b00; m_dly = 2'b01; end
    else if (we && !wp) begin m_lock = d[1:0]; m_dly = d[3:2]; end
    for (int i = 0; i < 2; i++) begin
      if (prst) m_flag[i] = 1'b0;
      else if (!mon[i]) m_flag[i] = 1'b0;
      else if (we) m_flag[i] = d[4+i];
    end
    e.r = {2'b00, m_flag, m_dly, m_lock};
    e.ok = (m_lock == 2'b00) && !wp;
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (reg_out !== e.r || wiper_wr_ok !== e.ok) begin
          fails++;
          $display("FAIL %s: reg_out=%h ok=%b expected reg_out=%h ok=%b",
                   e.tag, reg_out, wiper_wr_ok, e.r, e.ok);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    step(1, 1, 0, 8'h00, 0, 2'b00, "R1 defaults after initial load");
    step(0, 0, 1, 8'h05, 0, 2'b00, "R2 R4 lock 01 blocks wiper");
    step(0, 0, 1, 8'h0E, 0, 2'b00, "R4 lock 10 blocks wiper");
    step(0, 0, 1, 8'h0F, 0, 2'b00, "R4 lock 11 blocks wiper");
    step(0, 0, 1, 8'h08, 0, 2'b00, "R2 R4 lock 00 opens wiper");
    step(0, 0, 1, 8'h03, 1, 2'b00, "R3 write under protect ignored");
    step(0, 0, 0, 8'h00, 1, 2'b00, "R4 protect keeps wiper closed");
    step(0, 0, 0, 8'h00, 0, 2'b00, "R4 wiper reopens after protect");
    step(0, 0, 1, 8'h38, 0, 2'b11, "R6 set both flags");
    step(0, 0, 0, 8'h00, 0, 2'b01, "R7 flag 1 drops with monitor");
    step(0, 0, 1, 8'h38, 0, 2'b01, "R6 R7 set refused while monitor low");
    step(0, 0, 1, 8'h2F, 1, 2'b11, "R8 R9 flag write under protect");
    step(0, 0, 1, 8'hFF, 0, 2'b11, "R10 top bits read zero");
    step(0, 1, 0, 8'h00, 0, 2'b11, "R5 power-up reset clears flags only");
    step(0, 0, 1, 8'h34, 0, 2'b11, "R6 set flags again");
    step(0, 1, 1, 8'h34, 0, 2'b11, "R5 reset beats same-cycle flag write");
    step(1, 0, 1, 8'hC3, 0, 2'b11, "R11 initial load beats write");
    step(0, 0, 1, 8'h10, 0, 2'b10, "R6 R7 set with monitor 0 low");
    step(0, 0, 1, 8'h30, 0, 2'b11, "R6 set both");
    step(0, 0, 1, 8'h24, 0, 2'b11, "R8 write zero clears flag 0");
    @(negedge clk);
    wr_en = 0; init_load = 0; pwr_rst = 0;
    @(posedge clk); #5;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule